// File: doc/BRIEF.md
# Segmented Running-Sum Allocation Network

This block sits behind the sorting and merging logic of a combined input/output queued cell switch. Each slot it receives a vector of 2N entries already ordered by destination outlet. An entry is either an output-queue status record or a request from an input port. Entries that share a destination and follow each other form a group. For every entry the block produces the running total of an injected value, counted from the first entry of its group up to and including that entry.

A status record injects its occupancy. The first request after a status record injects zero, and each later request injects one. The total seen by a request is therefore the queue occupancy plus its rank among the requests for that outlet, which downstream logic compares with the speed-up to grant or deny the request. The address and activity fields are used only to find group edges and are not output. The record-type flag and an opaque per-entry tag travel alongside the sum unchanged.

The scan is built as log2(2N) registered combining stages. Stage s merges each entry with the entry 2^s positions above it unless a group edge lies between them. The network accepts one full vector every clock cycle.

Top module: `arsn_alloc_net`

## Requirements
- R1: Entry 0 always starts a group. Entry i (i ≥ 1) starts a new group when its address differs from entry i-1's address, or when entry i-1 has activity 0. Otherwise it continues the group of entry i-1. The activity of an entry has no effect on its own sum.
- R2: For i ≥ 1 the injected value depends on the record-type flags. Flag 0 (status record) injects the entry's count field. Flag 1 with flag 0 at entry i-1 injects 0. Flag 1 with flag 1 at entry i-1 injects 1.
- R3: Entry 0 injects its own count field whatever its record-type flag, so out_sum slice 0 equals in_cnt slice 0.
- R4: out_sum slice i (bits i*CW +: CW, CW = clog2(K_SPEED)+1) equals the sum of injected values from the first entry of i's group through entry i.
- R5: Sums saturate at 2^CW-1 and never wrap; a saturated sum stays saturated for the rest of its group.
- R6: out_src and out_tag equal in_src and in_tag of the same vector; address and activity do not reach the outputs.
- R7: A vector sampled with in_valid=1 on clock edge t appears with out_valid=1 right after edge t+LOG-1 (LOG = clog2(2·N_OUT)). out_valid tracks in_valid with that delay, and a new vector may enter on every edge.
- R8: While rst is high on a clock edge, all pipeline valid flags clear, so out_valid is 0 after reset and vectors in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_act | input | 2N | Per-entry activity flag |
| in_addr | input | 2N·AW | Per-entry destination outlet, AW = clog2(N_OUT) |
| in_src | input | 2N | Record type: 0 status, 1 request |
| in_cnt | input | 2N·CW | Per-entry status occupancy / count field |
| in_tag | input | 2N·TAG_W | Opaque per-entry tag |
| out_valid | output | 1 | Output vector present |
| out_src | output | 2N | Record type, delayed |
| out_sum | output | 2N·CW | Per-entry segmented running sum |
| out_tag | output | 2N·TAG_W | Tag, delayed |

## Verification
Saturation and a group break can land on adjacent entries of one vector. A group that has reached the ceiling is then followed at once by an entry whose address changes, or whose predecessor is inactive. The bench builds such vectors and checks that the saturated group stays at the maximum while the next entry restarts from its own injected value, with no carry across the edge. The same vectors are also sent back to back and with bubbles, and a reference scan in the bench checks every slice of every result against the rules.

// File: rtl/arsn_pkg.sv
package arsn_pkg;

  // Which value a combining cell feeds into the scan.
  typedef enum logic [1:0] {
    INJ_OWN  = 2'd0,  // status record: its own occupancy
    INJ_ZERO = 2'd1,  // first request after a status record
    INJ_ONE  = 2'd2   // request following a request
  } inj_kind_e;

  function automatic inj_kind_e inj_pick(input logic src_cur, input logic src_prev);
    if (!src_cur)      return INJ_OWN;
    else if (src_prev) return INJ_ONE;
    else               return INJ_ZERO;
  endfunction

endpackage

// File: rtl/arsn_seed.sv
module arsn_seed #(
  parameter int ENT = 8,
  parameter int AW  = 2,
  parameter int CW  = 3
) (
  input  logic [ENT-1:0]    act,
  input  logic [ENT*AW-1:0] addr,
  input  logic [ENT-1:0]    src,
  input  logic [ENT*CW-1:0] cnt,
  output logic [ENT*CW-1:0] seed,
  output logic [ENT-1:0]    head
);
  import arsn_pkg::*;

  // The last entry is never anyone's predecessor.
  logic unused_last_act;
  assign unused_last_act = act[ENT-1];

  for (genvar e = 0; e < ENT; e++) begin : g_cell
    if (e == 0) begin : g_top
      assign seed[CW-1:0] = cnt[CW-1:0];
      assign head[0]      = 1'b1;
    end else begin : g_mid
      logic      same_grp;
      inj_kind_e kind;
      assign same_grp = (addr[e*AW +: AW] == addr[(e-1)*AW +: AW]) && act[e-1];
      assign head[e]  = !same_grp;
      assign kind     = inj_pick(src[e], src[e-1]);
      assign seed[e*CW +: CW] = (kind == INJ_OWN) ? cnt[e*CW +: CW] :
                                (kind == INJ_ONE) ? CW'(1) : '0;
    end
  end

endmodule

// File: rtl/arsn_stage.sv
module arsn_stage #(
  parameter int ENT  = 8,
  parameter int CW   = 3,
  parameter int SW   = 8,
  parameter int DIST = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              v_i,
  input  logic [ENT*CW-1:0] sum_i,
  input  logic [ENT-1:0]    head_i,
  input  logic [SW-1:0]     side_i,
  output logic              v_o,
  output logic [ENT*CW-1:0] sum_o,
  output logic [ENT-1:0]    head_o,
  output logic [SW-1:0]     side_o
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic [ENT*CW-1:0] sum_n;
  logic [ENT-1:0]    head_n;

  for (genvar e = 0; e < ENT; e++) begin : g_comb
    if (e >= DIST) begin : g_join
      logic [CW:0] tot;
      assign tot = {1'b0, sum_i[e*CW +: CW]} + {1'b0, sum_i[(e-DIST)*CW +: CW]};
      assign sum_n[e*CW +: CW] = head_i[e] ? sum_i[e*CW +: CW] :
                                 (tot[CW] ? SAT : tot[CW-1:0]);
      assign head_n[e] = head_i[e] | head_i[e-DIST];
    end else begin : g_pass
      assign sum_n[e*CW +: CW] = sum_i[e*CW +: CW];
      assign head_n[e]         = head_i[e];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    sum_o  <= sum_n;
    head_o <= head_n;
    side_o <= side_i;
  end

endmodule

// File: rtl/arsn_alloc_net.sv
module arsn_alloc_net #(
  parameter int N_OUT   = 4,
  parameter int K_SPEED = 4,
  parameter int TAG_W   = 3,
  localparam int ENT    = 2 * N_OUT,
  localparam int AW     = $clog2(N_OUT),
  localparam int CW     = $clog2(K_SPEED) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [ENT-1:0]       in_act,
  input  logic [ENT*AW-1:0]    in_addr,
  input  logic [ENT-1:0]       in_src,
  input  logic [ENT*CW-1:0]    in_cnt,
  input  logic [ENT*TAG_W-1:0] in_tag,
  output logic                 out_valid,
  output logic [ENT-1:0]       out_src,
  output logic [ENT*CW-1:0]    out_sum,
  output logic [ENT*TAG_W-1:0] out_tag
);
  localparam int LOG = $clog2(ENT);
  localparam int SW  = ENT * (1 + TAG_W);

  logic              p_v    [LOG+1];
  logic [ENT*CW-1:0] p_sum  [LOG+1];
  logic [ENT-1:0]    p_head [LOG+1];
  logic [SW-1:0]     p_side [LOG+1];

  arsn_seed #(.ENT(ENT), .AW(AW), .CW(CW)) u_seed (
    .act  (in_act),
    .addr (in_addr),
    .src  (in_src),
    .cnt  (in_cnt),
    .seed (p_sum[0]),
    .head (p_head[0])
  );

  assign p_v[0]    = in_valid;
  assign p_side[0] = {in_src, in_tag};

  for (genvar s = 0; s < LOG; s++) begin : g_stage
    arsn_stage #(.ENT(ENT), .CW(CW), .SW(SW), .DIST(1 << s)) u_stg (
      .clk    (clk),
      .rst    (rst),
      .v_i    (p_v[s]),
      .sum_i  (p_sum[s]),
      .head_i (p_head[s]),
      .side_i (p_side[s]),
      .v_o    (p_v[s+1]),
      .sum_o  (p_sum[s+1]),
      .head_o (p_head[s+1]),
      .side_o (p_side[s+1])
    );
  end

  // Final heads are all set by construction; they are not an output.
  logic [ENT-1:0] unused_heads;
  assign unused_heads = p_head[LOG];

  assign out_valid = p_v[LOG];
  assign out_sum   = p_sum[LOG];
  assign {out_src, out_tag} = p_side[LOG];

endmodule

// File: rtl/arsn_alloc_net_chk.sv
module arsn_alloc_net_chk #(
  parameter int N_OUT   = 4,
  parameter int K_SPEED = 4,
  parameter int TAG_W   = 3,
  localparam int ENT    = 2 * N_OUT,
  localparam int AW     = $clog2(N_OUT),
  localparam int CW     = $clog2(K_SPEED) + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [ENT-1:0]       in_act,
  input logic [ENT*AW-1:0]    in_addr,
  input logic [ENT-1:0]       in_src,
  input logic [ENT*CW-1:0]    in_cnt,
  input logic [ENT*TAG_W-1:0] in_tag,
  input logic                 out_valid,
  input logic [ENT-1:0]       out_src,
  input logic [ENT*CW-1:0]    out_sum,
  input logic [ENT*TAG_W-1:0] out_tag
);
  localparam int LOG = $clog2(ENT);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic                 d_v    [LOG];
  logic [ENT-1:0]       d_act  [LOG];
  logic [ENT*AW-1:0]    d_addr [LOG];
  logic [ENT-1:0]       d_src  [LOG];
  logic [ENT*CW-1:0]    d_cnt  [LOG];
  logic [ENT*TAG_W-1:0] d_tag  [LOG];

  always_ff @(posedge clk) begin
    if (rst) for (int s = 0; s < LOG; s++) d_v[s] <= 1'b0;
    else begin
      d_v[0] <= in_valid;
      for (int s = 1; s < LOG; s++) d_v[s] <= d_v[s-1];
    end
    d_act[0] <= in_act; d_addr[0] <= in_addr; d_src[0] <= in_src;
    d_cnt[0] <= in_cnt; d_tag[0] <= in_tag;
    for (int s = 1; s < LOG; s++) begin
      d_act[s] <= d_act[s-1]; d_addr[s] <= d_addr[s-1]; d_src[s] <= d_src[s-1];
      d_cnt[s] <= d_cnt[s-1]; d_tag[s] <= d_tag[s-1];
    end
  end

  logic unused_chk_act;
  assign unused_chk_act = d_act[LOG-1][ENT-1];

  // R7 / R8: output valid mirrors the delayed input valid
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid == d_v[LOG-1]);

  // R6: side fields travel with the sum
  p_side_pass_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_src == d_src[LOG-1] && out_tag == d_tag[LOG-1]));

  // R3: entry 0 keeps its own count
  p_top_cell_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sum[CW-1:0] == d_cnt[LOG-1][CW-1:0]);

  for (genvar e = 1; e < ENT; e++) begin : g_ent
    logic          same;
    logic [CW-1:0] inj;
    assign same = (d_addr[LOG-1][e*AW +: AW] == d_addr[LOG-1][(e-1)*AW +: AW])
                  && d_act[LOG-1][e-1];
    assign inj  = !d_src[LOG-1][e] ? d_cnt[LOG-1][e*CW +: CW] :
                  (d_src[LOG-1][e-1] ? CW'(1) : CW'(0));

    // R1 / R2: a group edge restarts from the injected value alone
    p_group_edge_r1: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !same) |-> out_sum[e*CW +: CW] == inj);

    // R4: inside a group the running sum never falls
    p_monotone_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && same) |-> out_sum[e*CW +: CW] >= out_sum[(e-1)*CW +: CW]);

    // R5: saturation holds to the end of the group
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && same && out_sum[(e-1)*CW +: CW] == SAT) |-> out_sum[e*CW +: CW] == SAT);
  end

endmodule

bind arsn_alloc_net arsn_alloc_net_chk #(
  .N_OUT(N_OUT), .K_SPEED(K_SPEED), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_act(in_act), .in_addr(in_addr),
  .in_src(in_src), .in_cnt(in_cnt), .in_tag(in_tag), .out_valid(out_valid),
  .out_src(out_src), .out_sum(out_sum), .out_tag(out_tag)
);

// File: tb/arsn_alloc_net_tb.sv
module arsn_alloc_net_tb;
  localparam int N_OUT = 4, K_SPEED = 4, TAG_W = 3;
  localparam int ENT = 2 * N_OUT, AW = $clog2(N_OUT), CW = $clog2(K_SPEED) + 1;
  localparam int LOG = $clog2(ENT);
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [ENT-1:0] in_act = '0, in_src = '0;
  logic [ENT*AW-1:0] in_addr = '0;
  logic [ENT*CW-1:0] in_cnt = '0;
  logic [ENT*TAG_W-1:0] in_tag = '0;
  logic out_valid;
  logic [ENT-1:0] out_src;
  logic [ENT*CW-1:0] out_sum;
  logic [ENT*TAG_W-1:0] out_tag;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [ENT*CW-1:0] q_sum[$];
  logic [ENT-1:0] q_src[$];
  logic [ENT*TAG_W-1:0] q_tag[$];
  int q_cyc[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  arsn_alloc_net #(.N_OUT(N_OUT), .K_SPEED(K_SPEED), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_act(in_act), .in_addr(in_addr),
    .in_src(in_src), .in_cnt(in_cnt), .in_tag(in_tag), .out_valid(out_valid),
    .out_src(out_src), .out_sum(out_sum), .out_tag(out_tag));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference scan written from R1..R5.
  function automatic logic [ENT*CW-1:0] ref_sums(input logic [ENT-1:0] act,
      input logic [ENT*AW-1:0] addr, input logic [ENT-1:0] src, input logic [ENT*CW-1:0] cnt);
    logic [ENT*CW-1:0] r;
    int run = 0;
    for (int i = 0; i < ENT; i++) begin
      int v;
      bit head;
      head = (i == 0) || (addr[i*AW +: AW] != addr[(i-1)*AW +: AW]) || !act[i-1];
      if (i == 0 || !src[i]) v = int'(cnt[i*CW +: CW]);
      else v = src[i-1] ? 1 : 0;
      run = head ? v : run + v;
      if (run > MAXV) run = MAXV;
      r[i*CW +: CW] = CW'(run);
    end
    return r;
  endfunction

  task automatic drive_raw(input logic [ENT-1:0] act, input logic [ENT*AW-1:0] addr,
      input logic [ENT-1:0] src, input logic [ENT*CW-1:0] cnt, input logic [ENT*TAG_W-1:0] tag);
    @(negedge clk);
    in_valid = 1'b1; in_act = act; in_addr = addr; in_src = src; in_cnt = cnt; in_tag = tag;
    q_sum.push_back(ref_sums(act, addr, src, cnt));
    q_src.push_back(src);
    q_tag.push_back(tag);
    q_cyc.push_back(cyc + LOG);
  endtask

  task automatic drive(input logic [ENT-1:0] act, input int a[ENT],
      input logic [ENT-1:0] src, input int c[ENT]);
    logic [ENT*AW-1:0] ad;
    logic [ENT*CW-1:0] cn;
    logic [ENT*TAG_W-1:0] tg;
    for (int i = 0; i < ENT; i++) begin
      ad[i*AW +: AW] = AW'(a[i]);
      cn[i*CW +: CW] = CW'(c[i]);
      tg[i*TAG_W +: TAG_W] = TAG_W'(i + cyc);
    end
    drive_raw(act, ad, src, cn, tg);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_act = ~in_act;  // ignored while invalid
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q_sum.size() == 0) chk("R7 unexpected out_valid", 1, 0);
        else begin
          logic [ENT*CW-1:0] es;
          logic [ENT-1:0] esr;
          logic [ENT*TAG_W-1:0] etg;
          int ec;
          es = q_sum.pop_front(); esr = q_src.pop_front();
          etg = q_tag.pop_front(); ec = q_cyc.pop_front();
          chk("R7 latency", cyc, ec);
          for (int i = 0; i < ENT; i++)
            chk($sformatf("R4 sum entry %0d", i), int'(out_sum[i*CW +: CW]), int'(es[i*CW +: CW]));
          chk("R6 src pass", int'(out_src), int'(esr));
          chk("R6 tag pass", int'(out_tag), int'(etg));
        end
      end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
        chk("R7 missing out_valid", 0, 1);
        void'(q_sum.pop_front()); void'(q_src.pop_front());
        void'(q_tag.pop_front()); void'(q_cyc.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 out_valid after reset", int'(out_valid), 0);

    // R2 R3 R5: one group of requests, entry 0 keeps its count, climbs to the ceiling
    drive(8'hFF, '{0,0,0,0,0,0,0,0}, 8'hFF, '{2,5,5,5,5,5,5,5});
    idle(LOG);
    chk("R3 entry0 own count", int'(out_sum[CW-1:0]), 2);
    chk("R5 saturated tail", int'(out_sum[7*CW +: CW]), MAXV);

    // R1 R2: status then requests in several groups (back to back with next)
    drive(8'hFF, '{0,0,1,1,1,2,3,3}, 8'b1001_1010, '{3,7,1,7,7,5,2,7});
    // R1: inactive predecessor at entry 2 breaks the group at entry 3
    drive(8'b1111_1011, '{1,1,1,1,1,1,1,1}, 8'b1111_1110, '{4,7,7,7,7,7,7,7});
    // R5 with R1: saturated group followed directly by an address change
    drive(8'hFF, '{0,0,0,0,1,1,1,1}, 8'b1110_1110, '{7,0,0,0,6,0,0,0});
    idle(LOG);
    chk("R1 restart after saturation", int'(out_sum[4*CW +: CW]), 6);
    chk("R5 held at max", int'(out_sum[3*CW +: CW]), MAXV);

    // R7: random vectors, back to back and with bubbles
    for (int n = 0; n < 60; n++) begin
      drive_raw(ENT'($urandom), (ENT*AW)'($urandom), ENT'($urandom),
                (ENT*CW)'($urandom), (ENT*TAG_W)'($urandom));
      if (n % 7 == 3) idle(n % 3 + 1);
    end
    idle(LOG + 2);

    // R8: reset discards vectors in flight
    drive(8'hFF, '{0,0,0,0,0,0,0,0}, 8'h00, '{1,1,1,1,1,1,1,1});
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    q_sum.delete(); q_src.delete(); q_tag.delete(); q_cyc.delete();
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < LOG + 2; k++) begin
      @(negedge clk);
      chk("R8 flushed", int'(out_valid), 0);
    end

    chk("R7 scoreboard drained", q_sum.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule